// File: doc/BRIEF.md
# I2C Register Port Slave

This block is an I2C target that gives a host access to an on-chip register file. It watches SCL and SDA with the system clock and detects START and STOP conditions. It receives a chip address byte whose two low address bits come from strap pins. It then receives a pointer byte that selects a register and carries an auto-increment flag. After that come data bytes. Each byte the target accepts is acknowledged by pulling SDA low in the ninth clock.

On the register side the block raises a one-cycle write strobe with address and data for every written byte. For reads it presents the current pointer as the address and takes the register value back on a read-data input. It then shifts that value out MSB first.

When auto-increment is set, the pointer steps after each data byte, so a burst walks through consecutive registers. When the flag is clear, every byte goes to the same register. A repeated START restarts the address phase and keeps the pointer, so a write of the pointer followed by a repeated START and a read returns data from the chosen register.

Top module: `i2c_regport`

## Requirements
- R1: The first byte after a START is the chip address, sent MSB first: bits 7..3 must equal the device identifier `10010`, bits 2..1 must equal `strap_i[1:0]`, and bit 0 is the direction (0 = write, 1 = read). On a match the target acknowledges. On a mismatch it leaves SDA released and ignores every bit until the next START, so no later byte is acknowledged and no write strobe occurs.
- R2: Every byte is 8 bits, bit 7 first, and is sampled on rising SCL. The ninth clock is the acknowledge slot. The target holds `sda_oe` high (SDA low) through that slot after a matching address, after the pointer byte and after every data byte of a write.
- R3: The byte after a write address is the pointer byte: bits 6..0 become the register pointer and bit 7 becomes the auto-increment flag.
- R4: Each data byte of a write produces exactly one `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R5: With the flag set, the pointer advances by one after each data byte and wraps from 127 to 0. With the flag clear, it stays put, so all bytes of the transfer land in one register.
- R6: After a read address, the target shifts out `reg_rdata` for `reg_addr` MSB first, one byte per nine clocks. After each byte the pointer advances only when the flag is set.
- R7: When the master does not acknowledge a read byte, the target releases SDA and drives nothing until the next START.
- R8: A START or repeated START makes the target expect a chip address and leaves the pointer and flag unchanged. A STOP returns the target to idle with SDA released.
- R9: After reset `sda_oe` and `reg_we` are low, and the pointer and flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Sensed level of the serial data line |
| sda_oe | output | 1 | When high, the open-drain pad pulls SDA low |
| strap_i | input | 2 | Strap pins giving address bits 2..1 |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 7 | Register pointer, used for both writes and reads |
| reg_wdata | output | 8 | Data for the write strobe |
| reg_rdata | input | 8 | Register value at `reg_addr` |

## Verification
The pointer step at the end of a data byte's acknowledge slot can meet a repeated START that the master issues right after that slot. The bench provokes this by writing a pointer near the top of the range with auto-increment set, issuing a repeated START without a STOP, and reading at once. It judges the result by requiring that the read return the register that the bench's own model places after the wrapped pointer. A second pairing is the read-data load and the first driven bit after the address acknowledge. This one is judged by comparing every received byte with the model.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int BYTE_W  = 8;
  localparam int PTR_W   = BYTE_W - 1;
  localparam int STRAP_W = 2;
  localparam int ID_W    = BYTE_W - 1 - STRAP_W;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA
  } xfer_st_t;

  // Chip address byte matches identifier plus strap bits (bit 0 is direction)
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ID_W-1:0] id,
                                    input logic [STRAP_W-1:0] strap);
    return b[BYTE_W-1:1] == {id, strap};
  endfunction

  // Pointer after one data byte
  function automatic logic [PTR_W-1:0] ptr_advance(input logic [PTR_W-1:0] p,
                                                   input logic inc);
    return inc ? PTR_W'(p + 1'b1) : p;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[MSB];
      sda_q <= sda_p[MSB];
    end
  end

  assign scl_s    = scl_p[MSB];
  assign sda_s    = sda_p[MSB];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit
  import i2c_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              step,
  output logic [PTR_W-1:0]  ptr,
  output logic              incr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      incr <= 1'b0;
    end else if (load) begin
      ptr  <= load_val[PTR_W-1:0];
      incr <= load_val[BYTE_W-1];
    end else if (step) begin
      ptr <= ptr_advance(ptr, incr);
    end
  end

  // R5: flag clear keeps the pointer
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !incr && !load) |=> $stable(ptr));

  // R5: flag set moves to the next register, wrapping
  p_ptr_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && incr && !load) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));
endmodule

// File: rtl/i2c_xfer_ctrl.sv
module i2c_xfer_ctrl
  import i2c_regport_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_ID = 5'b10010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  reg_rdata,
  output logic               sda_oe,
  output logic               ptr_load,
  output logic [BYTE_W-1:0]  ptr_load_val,
  output logic               ptr_step,
  output logic               reg_we,
  output logic [BYTE_W-1:0]  reg_wdata
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  xfer_st_t          state;
  logic [CNT_W-1:0]  bitcnt;
  logic              ack_phase, ack_drive, rw, load_pend, mnack;
  logic [BYTE_W-1:0] shreg, txreg;

  // Named internal events
  logic byte_done, ack_end, hit, rx_state;
  assign rx_state  = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);
  assign byte_done = scl_fall && !ack_phase && (bitcnt == LAST_BIT);
  assign ack_end   = scl_fall && ack_phase;
  assign hit       = addr_hit(shreg, DEV_ID, strap);

  assign ptr_load     = byte_done && (state == ST_PTR);
  assign ptr_load_val = shreg;
  assign ptr_step     = ack_end && ((state == ST_WDATA) || (state == ST_RDATA));

  assign sda_oe = ack_drive |
                  ((state == ST_RDATA) && !ack_phase && !load_pend && !txreg[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      ack_phase <= 1'b0;
      ack_drive <= 1'b0;
      rw        <= 1'b0;
      load_pend <= 1'b0;
      mnack     <= 1'b0;
      shreg     <= '0;
      txreg     <= '0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_ev || stop_ev) begin
        state     <= start_ev ? ST_ADDR : ST_IDLE;
        bitcnt    <= '0;
        ack_phase <= 1'b0;
        ack_drive <= 1'b0;
        load_pend <= 1'b0;
      end else begin
        if (load_pend) begin
          txreg     <= reg_rdata;
          load_pend <= 1'b0;
        end
        if (rx_state) begin
          if (scl_rise && !ack_phase) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + CNT_W'(1);
          end
          if (byte_done) begin
            bitcnt <= '0;
            if (state == ST_ADDR && !hit) begin
              state <= ST_IDLE;
            end else begin
              ack_phase <= 1'b1;
              ack_drive <= 1'b1;
              if (state == ST_ADDR) rw <= shreg[0];
              if (state == ST_WDATA) begin
                reg_we    <= 1'b1;
                reg_wdata <= shreg;
              end
            end
          end
          if (ack_end) begin
            ack_phase <= 1'b0;
            ack_drive <= 1'b0;
            if (state == ST_ADDR) begin
              if (rw) begin
                state     <= ST_RDATA;
                load_pend <= 1'b1;
              end else begin
                state <= ST_PTR;
              end
            end else if (state == ST_PTR) begin
              state <= ST_WDATA;
            end
          end
        end else if (state == ST_RDATA) begin
          if (scl_rise) begin
            if (ack_phase) mnack <= sda_s;
            else           bitcnt <= bitcnt + CNT_W'(1);
          end
          if (scl_fall && !ack_phase) begin
            if (bitcnt == LAST_BIT) begin
              ack_phase <= 1'b1;
              bitcnt    <= '0;
            end else begin
              txreg <= {txreg[BYTE_W-2:0], 1'b0};
            end
          end
          if (ack_end) begin
            ack_phase <= 1'b0;
            if (mnack) state <= ST_IDLE;
            else       load_pend <= 1'b1;
          end
        end
      end
    end
  end

  // R1: a foreign address is never acknowledged
  p_addr_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == ST_ADDR && !hit) |=> (!sda_oe && state == ST_IDLE));

  // R2: bit counter never passes one byte
  p_bitcnt_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= LAST_BIT);

  // R4: write strobe only inside a data byte's acknowledge slot
  p_we_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (ack_phase && state == ST_WDATA));

  // R7: master NACK ends driving
  p_nack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_end && state == ST_RDATA && mnack) |=> (!sda_oe && state == ST_IDLE));

  // R8: START restarts the address phase with SDA released
  p_start_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_ADDR && bitcnt == '0 && !sda_oe));

  // R8: STOP returns to idle
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE && !sda_oe));
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter logic [4:0] DEV_ID      = 5'b10010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_i,
  output logic              reg_we,
  output logic [6:0]        reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic ptr_load, ptr_step, incr;
  logic [BYTE_W-1:0] ptr_load_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_xfer_ctrl #(.DEV_ID(DEV_ID)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_s        (sda_s),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_ev     (start_ev),
    .stop_ev      (stop_ev),
    .strap        (strap_i),
    .reg_rdata    (reg_rdata),
    .sda_oe       (sda_oe),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .ptr_step     (ptr_step),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata)
  );

  i2c_ptr_unit u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_load_val),
    .step     (ptr_step),
    .ptr      (reg_addr),
    .incr     (incr)
  );

  // R9: idle outputs while reset is applied and right after
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> (!reg_we && !sda_oe));
endmodule

// File: tb/i2c_regport_tb.sv
module i2c_regport_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap_pins = 2'b00;
  logic       sda_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [6:0] exp_ptr = '0;
  logic       exp_inc = 1'b0;
  int n_chk = 0, n_fail = 0, we_cnt = 0;
  bit done = 0;

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (rst_n && reg_we) begin
    mem[reg_addr] <= reg_wdata;
    we_cnt++;
  end

  i2c_regport u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap_pins), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [6:0] nxt(input logic [6:0] p, input logic inc);
    int v;
    v = inc ? (int'(p) + 1) % 128 : int'(p);
    return 7'(v);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_bus; q(); scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    wbit(~mack);
  endtask

  function automatic int mem_diff();
    int c = 0;
    for (int a = 0; a < 128; a++) if (mem[a] !== exp_mem[a]) c++;
    return c;
  endfunction

  task automatic wr_xfer(input logic [1:0] s_used, input logic [6:0] p,
                         input logic inc, input int n, input bit stop_end);
    logic ack, match;
    logic [7:0] d;
    int we0;
    match = (s_used == strap_pins);
    we0 = we_cnt;
    do_start();
    send_byte({5'b10010, s_used, 1'b0}, ack);
    chk("R1 address ack", int'(ack), int'(match));
    send_byte({inc, p}, ack);
    chk(match ? "R3 pointer ack" : "R1 pointer ignored", int'(ack), int'(match));
    if (match) begin
      exp_ptr = p;
      exp_inc = inc;
    end
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      chk(match ? "R2 data ack" : "R1 data ignored", int'(ack), int'(match));
      if (match) begin
        exp_mem[exp_ptr] = d;
        exp_ptr = nxt(exp_ptr, exp_inc);
      end
    end
    if (stop_end) begin
      do_stop();
      chk("R8 released after STOP", int'(sda_oe), 0);
    end
    repeat (4) @(negedge clk);
    chk("R4 strobe count", we_cnt - we0, match ? n : 0);
    chk("R5 register contents", mem_diff(), 0);
  endtask

  task automatic rd_xfer(input logic [1:0] s_used, input int n);
    logic ack, match;
    logic [7:0] v;
    match = (s_used == strap_pins);
    do_start();
    send_byte({5'b10010, s_used, 1'b1}, ack);
    chk("R1 read address ack", int'(ack), int'(match));
    if (match) begin
      for (int k = 0; k < n; k++) begin
        recv_byte(v, k != n - 1);
        chk("R6 read data", int'(v), int'(exp_mem[exp_ptr]));
        exp_ptr = nxt(exp_ptr, exp_inc);
      end
      chk("R7 released after NACK", int'(sda_oe), 0);
    end
    do_stop();
    chk("R8 released after STOP", int'(sda_oe), 0);
  endtask

  initial begin
    for (int a = 0; a < 128; a++) begin
      mem[a]     = 8'(a * 3 + 1);
      exp_mem[a] = 8'(a * 3 + 1);
    end
    void'($urandom(32'h1c2d));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 sda_oe after reset", int'(sda_oe), 0);
    chk("R9 reg_we after reset", int'(reg_we), 0);
    chk("R9 pointer after reset", int'(reg_addr), 0);
    strap_pins = 2'b10;
    repeat (4) @(negedge clk);
    // R9: a read before any pointer write returns register 0
    rd_xfer(2'b10, 1);
    // R5: flag clear, all bytes to one register
    wr_xfer(2'b10, 7'd5, 1'b0, 3, 1'b1);
    // R6: reads without increment repeat one register
    rd_xfer(2'b10, 2);
    // R8 / R5: wrap 126..0 then repeated START into a read
    wr_xfer(2'b10, 7'd126, 1'b1, 3, 1'b0);
    rd_xfer(2'b10, 2);
    // R1: wrong strap bits are ignored
    wr_xfer(2'b01, 7'd9, 1'b1, 2, 1'b1);
    rd_xfer(2'b00, 1);
    // Constrained random mix
    for (int it = 0; it < 30; it++) begin
      logic [1:0] s_used;
      int op;
      strap_pins = 2'($urandom % 4);
      repeat (8) @(negedge clk);
      s_used = (($urandom % 5) == 0) ? (strap_pins ^ 2'(1 + $urandom % 3)) : strap_pins;
      op = int'($urandom % 4);
      if (op < 2)
        wr_xfer(s_used, 7'($urandom % 128), 1'($urandom % 2), 1 + int'($urandom % 4), 1'b1);
      else if (op == 2)
        rd_xfer(s_used, 1 + int'($urandom % 4));
      else begin
        wr_xfer(strap_pins, 7'($urandom % 128), 1'($urandom % 2), 1 + int'($urandom % 3), 1'b0);
        rd_xfer(strap_pins, 1 + int'($urandom % 3));
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule